// File: doc/BRIEF.md
# Free-Running Bus Timer with Coherent Byte Reads

This block is a 16-bit up-counter that sits on the byte-wide register bus of a small 8-bit controller. The counter is fed from the bus clock through a fixed divide-by-four prescaler. It runs without pause from the moment reset is released, so the whole count sequence repeats every 262,144 bus clocks. Software reads the count one byte at a time, through either of two register pairs. When the high byte is read, the block holds the low byte so that a later low-byte read completes a consistent 16-bit snapshot.

When the count wraps past its maximum, an overflow flag is set. That flag, gated by an enable input, drives a registered interrupt line. Software clears the flag by reading the status register while the flag is set and then reading the low byte of the main pair. The second pair returns the same count but never clears the flag, so it can be polled freely. There is no data path into the counter. A write to either low-byte address restarts the counter and the prescaler from the reset value.

Top module: `frc_timer`

## Requirements
- R1: After synchronous reset the count is 16'hFFFC, the prescaler phase is zero, no high-byte snapshot is pending, the overflow flag is clear and `irq` is 0.
- R2: The count increments once every four bus clocks: on the 4th, 8th, 12th, ... rising edge after reset or after a reload.
- R3: A high-byte read at 8'h19 or 8'h1B returns the live bits [15:8] and, if no snapshot is pending, captures the live bits [7:0]. Further high-byte reads leave that capture unchanged. A low-byte read at 8'h1A or 8'h1C returns the capture while one is pending and ends the snapshot. With no snapshot pending, a low-byte read returns the live bits [7:0].
- R4: A write to 8'h1A or 8'h1C reloads the count with 16'hFFFC and restarts the prescaler, whatever the data value.
- R5: The overflow flag sets on the increment that takes the count from 16'hFFFF to 16'h0000.
- R6: `irq` equals the overflow flag ANDed with `ovf_ie`, registered on the bus clock, so it follows the flag by one cycle.
- R7: A `stat_rd` pulse while the flag is set arms a clear. A later low-byte read at 8'h1A then clears the flag. A low-byte read at 8'h1C never clears the flag or the arming, and a read at 8'h1A without arming leaves the flag set.
- R8: Writes to 8'h19 and 8'h1B have no effect on the count. A read of any other address returns 8'h00, and `rdata` is 8'h00 whenever `rd_en` is low.
- R9: If a rollover coincides with an armed clearing read, the flag stays set and the arming is discarded, so a second clearing read needs a fresh `stat_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data (value not used by the counter) |
| rdata | output | 8 | Read data, combinational in the strobe cycle |
| ovf_ie | input | 1 | Overflow interrupt enable |
| stat_rd | input | 1 | Pulse marking a status-register read |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The bench reads the low byte long after a high-byte read and after the high byte has changed. A design that refreshed or bypassed the holding byte would return a torn value. It times a main-pair low read to land exactly on the rollover edge. A design that let the clear win would drop `irq`, and one that kept the arming would clear the flag on the next unarmed read. It also polls the alternate pair between the arming pulse and the clearing read, which exposes a design that lets the alias clear the flag. A reload written in mid-prescale must restart the four-clock phase, or the next increment comes early.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int PRE_W    = 2;
    localparam logic [CNT_W-1:0] CNT_RESET = 16'hFFFC;

    localparam logic [7:0] A_MAIN_HI = 8'h19;
    localparam logic [7:0] A_MAIN_LO = 8'h1A;
    localparam logic [7:0] A_ALT_HI  = 8'h1B;
    localparam logic [7:0] A_ALT_LO  = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MAIN_HI,
        SEL_MAIN_LO,
        SEL_ALT_HI,
        SEL_ALT_LO
    } reg_sel_e;

    typedef struct packed {
        logic hi_rd;
        logic lo_rd;
        logic main_lo_rd;
        logic lo_wr;
        logic mapped;
    } bus_ev_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            A_MAIN_HI: return SEL_MAIN_HI;
            A_MAIN_LO: return SEL_MAIN_LO;
            A_ALT_HI:  return SEL_ALT_HI;
            A_ALT_LO:  return SEL_ALT_LO;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/frc_prescale.sv
module frc_prescale
    import frc_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam logic [PW-1:0] LAST = '1;

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || restart) phase <= '0;
        else                phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    p_phase_r2: assert property (@(posedge clk) disable iff (rst)
        (!restart && tick) |=> (phase == '0));
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == '0) && !tick);
endmodule

// File: rtl/frc_count.sv
module frc_count
    import frc_pkg::*;
#(
    parameter int W = CNT_W,
    parameter logic [W-1:0] RST_VAL = CNT_RESET
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || load) cnt <= RST_VAL;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assign wrap = tick && !load && (cnt == TOP);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && tick) |=> (cnt == $past(cnt) + 1'b1));
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == RST_VAL));
endmodule

// File: rtl/frc_snap.sv
module frc_snap
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic [BYTE_W-1:0] live_lo,
    output logic [BYTE_W-1:0] lo_out
);
    logic              pending;
    logic [BYTE_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held    <= '0;
        end else if (lo_rd) begin
            pending <= 1'b0;
        end else if (hi_rd && !pending) begin
            pending <= 1'b1;
            held    <= live_lo;
        end
    end

    assign lo_out = pending ? held : live_lo;

    p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (pending && hi_rd && !lo_rd) |=> (pending && $stable(held)));
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!pending && hi_rd && !lo_rd) |=> (held == $past(live_lo)));
    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> !pending);
endmodule

// File: rtl/frc_ovf.sv
module frc_ovf (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic clr_rd,
    input  logic ie,
    output logic irq
);
    logic flag;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set_ev) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (armed && clr_rd) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (flag && stat_rd) begin
            armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= flag & ie;
    end

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);
    p_irq_on_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && ie) |=> irq);
    p_irq_off_r6: assert property (@(posedge clk) disable iff (rst)
        !(flag && ie) |=> !irq);
    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_rd) |=> flag);
    p_setwins_r9: assert property (@(posedge clk) disable iff (rst)
        (set_ev && clr_rd) |=> (flag && !armed));
endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ovf_ie,
    input  logic       stat_rd,
    output logic       irq
);
    reg_sel_e          sel;
    bus_ev_t           ev;
    logic              tick;
    logic              wrap;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] lo_view;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;
    assign sel = decode_addr(addr);

    always_comb begin
        ev            = '0;
        ev.mapped     = (sel != SEL_NONE);
        ev.hi_rd      = rd_en && (sel == SEL_MAIN_HI || sel == SEL_ALT_HI);
        ev.lo_rd      = rd_en && (sel == SEL_MAIN_LO || sel == SEL_ALT_LO);
        ev.main_lo_rd = rd_en && (sel == SEL_MAIN_LO);
        ev.lo_wr      = wr_en && (sel == SEL_MAIN_LO || sel == SEL_ALT_LO);
    end

    frc_prescale u_pre (
        .clk(clk), .rst(rst), .restart(ev.lo_wr), .tick(tick)
    );

    frc_count u_cnt (
        .clk(clk), .rst(rst), .load(ev.lo_wr), .tick(tick),
        .cnt(cnt), .wrap(wrap)
    );

    frc_snap u_snap (
        .clk(clk), .rst(rst), .hi_rd(ev.hi_rd), .lo_rd(ev.lo_rd),
        .live_lo(cnt[BYTE_W-1:0]), .lo_out(lo_view)
    );

    frc_ovf u_ovf (
        .clk(clk), .rst(rst), .set_ev(wrap), .stat_rd(stat_rd),
        .clr_rd(ev.main_lo_rd), .ie(ovf_ie), .irq(irq)
    );

    always_comb begin
        rdata = '0;
        if (ev.hi_rd)      rdata = cnt[CNT_W-1:BYTE_W];
        else if (ev.lo_rd) rdata = lo_view;
    end

    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || !ev.mapped) |-> (rdata == '0));
    p_hiwr_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ev.lo_wr && !tick) |=> $stable(cnt));
endmodule

// File: tb/frc_timer_test.sv
module frc_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ovf_ie = 1'b0;
    logic       stat_rd = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;
    int mark     = 0;
    bit done     = 0;

    frc_timer uut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .ovf_ie(ovf_ie), .stat_rd(stat_rd),
        .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    function automatic int since();
        return edge_cnt - mark;
    endfunction

    function automatic logic [15:0] exp_cnt();
        return 16'hFFFC + 16'(since() / 4);
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_until(input int e);
        while (since() < e) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; addr = 8'h00;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        if (a == 8'h1A || a == 8'h1C) mark = edge_cnt;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00;
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq after reset", 16'(irq), 16'h0);
        rd(8'h19, d); check("R1 reset high byte", 16'(d), 16'hFF);
        rd(8'h1A, d); check("R1 reset low byte", 16'(d), 16'hFC);
    endtask

    task automatic t_prescale();
        logic [7:0] d;
        wr(8'h1A, 8'h55);
        wait_until(3);
        rd(8'h1A, d); check("R2 before fourth edge", 16'(d), 16'hFC);
        rd(8'h1A, d); check("R2 after fourth edge", 16'(d), 16'hFD);
        wait_until(11);
        rd(8'h1C, d); check("R2 alt low at edge 11", 16'(d), 16'hFE);
        rd(8'h1C, d); check("R2 alt low at edge 12", 16'(d), 16'hFF);
    endtask

    task automatic t_snapshot();
        logic [7:0] d;
        logic [15:0] first;
        wr(8'h1C, 8'h00);
        wait_until(10);
        first = exp_cnt();
        rd(8'h19, d); check("R3 first high read", 16'(d), 16'(first[15:8]));
        wait_until(30);
        rd(8'h1B, d); check("R3 second high read is live", 16'(d), 16'(exp_cnt() >> 8));
        wait_until(45);
        rd(8'h1A, d); check("R3 low read returns held byte", 16'(d), 16'(first[7:0]));
        wait_until(50);
        first = exp_cnt();
        rd(8'h1C, d); check("R3 unlatched low read is live", 16'(d), 16'(first[7:0]));
    endtask

    task automatic t_writes();
        logic [7:0] d;
        logic [15:0] e;
        wait_until(60);
        wr(8'h19, 8'h12);
        wr(8'h1B, 8'h34);
        e = exp_cnt();
        rd(8'h19, d); check("R8 high write ignored, high", 16'(d), 16'(e >> 8));
        rd(8'h1A, d); check("R8 high write ignored, low", 16'(d), 16'(e[7:0]));
        rd(8'h20, d); check("R8 unmapped read", 16'(d), 16'h00);
        addr = 8'h1A; #1 check("R8 idle rdata", 16'(rdata), 16'h00); addr = 8'h00;
        wr(8'h1C, 8'hA5);
        wait_until(2);
        wr(8'h1A, 8'h00);
        wait_until(3);
        rd(8'h1A, d); check("R4 reload restarts prescaler", 16'(d), 16'hFC);
        rd(8'h19, d); check("R4 reload high", 16'(d), 16'hFF);
        rd(8'h1A, d); check("R4 reload low after phase", 16'(d), 16'hFD);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        ovf_ie = 1'b1;
        pulse_stat();
        rd(8'h1A, d);
        wr(8'h1A, 8'h00);
        wait_until(3);
        check("R5 no flag before rollover", 16'(irq), 16'h0);
        wait_until(16);
        check("R6 irq lags flag by a cycle", 16'(irq), 16'h0);
        wait_until(17);
        check("R5 flag after rollover", 16'(irq), 16'h1);
        rd(8'h1C, d); check("R5 count wrapped", 16'(d), 16'h00);
        ovf_ie = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R6 enable masks irq", 16'(irq), 16'h0);
        ovf_ie = 1'b1;
        @(negedge clk);
        check("R6 irq returns with enable", 16'(irq), 16'h1);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        rd(8'h1A, d);
        @(negedge clk);
        check("R7 unarmed low read keeps flag", 16'(irq), 16'h1);
        pulse_stat();
        rd(8'h1C, d);
        @(negedge clk);
        check("R7 alt low read keeps flag", 16'(irq), 16'h1);
        rd(8'h1A, d);
        @(negedge clk);
        check("R7 armed low read clears flag", 16'(irq), 16'h0);
    endtask

    task automatic t_setwins();
        logic [7:0] d;
        wr(8'h1A, 8'h00);
        wait_until(17);
        check("R9 flag set for race", 16'(irq), 16'h1);
        pulse_stat();
        wr(8'h1A, 8'h00);
        wait_until(15);
        rd(8'h1A, d);
        @(negedge clk);
        check("R9 rollover beats clear", 16'(irq), 16'h1);
        rd(8'h1A, d);
        @(negedge clk);
        check("R9 arming discarded", 16'(irq), 16'h1);
        pulse_stat();
        rd(8'h1A, d);
        @(negedge clk);
        check("R9 fresh arming clears", 16'(irq), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mark = edge_cnt;
        t_reset();
        t_prescale();
        t_snapshot();
        t_writes();
        t_overflow();
        t_clear();
        t_setwins();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule